// File: doc/BRIEF.md
# Registered Subtractor with Arithmetic Flags

This block is one execution slice of a 16-bit processor. When its strobe is high it forms the destination operand minus the source operand, as the destination plus the bitwise inverse of the source plus one. It works at either full word width (16 bits) or byte width (8 bits). The difference goes into a result register, which takes the place of the destination. The arithmetic flags in a 16-bit status register are updated at the same edge.

The caller gives the current status word along with the operands. The block returns that word with only the four arithmetic flags replaced. Every other bit passes through unchanged, including the interrupt-enable bit and the two power-control bits. When the strobe is low, both registers hold their values.

Top module: `sub_flag_unit`

## Requirements
- R1: On a rising clock edge with `go` high, `res_q` becomes (dst + ~src + 1) at the selected width. In word mode (`byte_mode`=0) this is the full 16 bits, modulo 2^16.
- R2: In byte mode (`byte_mode`=1), `res_q[7:0]` is (dst[7:0] + ~src[7:0] + 1) mod 256, and `res_q[15:8]` is 0.
- R3: The carry flag, at `sr_q` bit 0, is the carry out of the top bit of the active width (bit 7 or bit 15). It is 1 when dst ≥ src unsigned (no borrow) and 0 when a borrow occurs.
- R4: The zero flag, at `sr_q` bit 1, is 1 exactly when the result at the active width is zero.
- R5: The negative flag, at `sr_q` bit 2, equals the top bit of the active-width result.
- R6: The overflow flag, at `sr_q` bit 8, is 1 exactly when dst and src differ in sign at the active width and the result's sign differs from dst's sign.
- R7: With `go` high, all `sr_q` bits other than 0, 1, 2 and 8 take their values from `sr_in`. This includes interrupt enable (bit 3), CPU halt (bit 4) and oscillator off (bit 5).
- R8: With `go` low, `res_q` and `sr_q` keep their previous values.
- R9: A synchronous reset (`rst` high at a clock edge) clears `sr_q` and `res_q` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Operation strobe |
| byte_mode | input | 1 | 1 = byte width, 0 = word width |
| src | input | 16 | Source operand (subtrahend) |
| dst | input | 16 | Destination operand (minuend) |
| sr_in | input | 16 | Status word before the operation |
| res_q | output | 16 | Registered difference, written back to the destination |
| sr_q | output | 16 | Registered status word after the operation |

## Verification
The assertions assume that `go`, `byte_mode`, the operands and `sr_in` hold stable around each rising edge and are never unknown after reset. This lets `$past` of an input stand for the value the registers captured. The stimulus drives every input on the falling edge, half a period away from the capturing edge. Operands are chosen on purpose to include equal values, zero, the sign boundaries 0x80/0x8000 and 0x7F/0x7FFF, and byte inputs with non-zero upper bytes. This makes the borrow, zero and overflow cases each occur in both widths.

// File: rtl/sub_flag_unit.sv
module sub_flag_unit #(
  parameter int W = 16,
  parameter int B = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic         byte_mode,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  input  logic [15:0]  sr_in,
  output logic [W-1:0] res_q,
  output logic [15:0]  sr_q
);
  localparam int CB = 0, ZB = 1, NB = 2, VB = 8;

  logic [W:0]   sum_w;
  logic [B:0]   sum_b;
  logic [W-1:0] res_d;
  logic         c_d, z_d, n_d, v_d;
  logic [15:0]  sr_d;

  assign sum_w = {1'b0, dst} + {1'b0, ~src} + {{W{1'b0}}, 1'b1};
  assign sum_b = {1'b0, dst[B-1:0]} + {1'b0, ~src[B-1:0]} + {{B{1'b0}}, 1'b1};

  always_comb begin
    if (byte_mode) begin
      res_d = {{(W-B){1'b0}}, sum_b[B-1:0]};
      c_d   = sum_b[B];
      n_d   = sum_b[B-1];
      v_d   = (dst[B-1] ^ src[B-1]) & (sum_b[B-1] ^ dst[B-1]);
    end else begin
      res_d = sum_w[W-1:0];
      c_d   = sum_w[W];
      n_d   = sum_w[W-1];
      v_d   = (dst[W-1] ^ src[W-1]) & (sum_w[W-1] ^ dst[W-1]);
    end
    z_d = (res_d == '0);
    sr_d = sr_in;
    sr_d[CB] = c_d;
    sr_d[ZB] = z_d;
    sr_d[NB] = n_d;
    sr_d[VB] = v_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      sr_q  <= '0;
    end else if (go) begin
      res_q <= res_d;
      sr_q  <= sr_d;
    end
  end

  a_r9_reset_clears: assert property (@(posedge clk) rst |=> (sr_q == 16'h0 && res_q == '0));
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst) !go |=> ($stable(res_q) && $stable(sr_q)));
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst) (go && byte_mode) |=> res_q[W-1:B] == '0);
  a_r4_zero_flag: assert property (@(posedge clk) disable iff (rst) go |=> sr_q[ZB] == (res_q == '0));
  a_r5_neg_flag: assert property (@(posedge clk) disable iff (rst)
    go |=> sr_q[NB] == ($past(byte_mode) ? res_q[B-1] : res_q[W-1]));
  a_r7_mode_bits: assert property (@(posedge clk) disable iff (rst)
    go |=> (sr_q[7:3] == $past(sr_in[7:3]) && sr_q[15:9] == $past(sr_in[15:9])));
  a_r3_carry_word: assert property (@(posedge clk) disable iff (rst)
    (go && !byte_mode) |=> sr_q[CB] == ($past(dst) >= $past(src)));
endmodule

// File: tb/sim_sub_flag_unit.sv
module sim_sub_flag_unit;
  logic clk = 0, rst = 1, go = 0, byte_mode = 0;
  logic [15:0] src = 0, dst = 0, sr_in = 0;
  logic [15:0] res_q, sr_q;
  int vectors = 0, errors = 0;
  logic [15:0] exp_res = 0, exp_sr = 0;

  always #4 clk = ~clk;

  sub_flag_unit u0 (.clk, .rst, .go, .byte_mode, .src, .dst, .sr_in, .res_q, .sr_q);

  task automatic model();
    int w, d, s, r, msk, top;
    if (rst) begin exp_res = 0; exp_sr = 0; return; end
    if (!go) return;
    w = byte_mode ? 8 : 16;
    msk = (1 << w) - 1;
    top = 1 << (w - 1);
    d = dst & msk; s = src & msk;
    r = (d - s) & msk;
    exp_res = r[15:0];
    exp_sr = sr_in;
    exp_sr[0] = (d >= s);
    exp_sr[1] = (r == 0);
    exp_sr[2] = (r & top) != 0;
    exp_sr[8] = (((d ^ s) & top) != 0) && (((r ^ d) & top) != 0);
  endtask

  task automatic cmp(string tag);
    vectors++;
    if (res_q !== exp_res || sr_q !== exp_sr) begin
      errors++;
      $display("FAIL %s: res=%h sr=%h expected res=%h sr=%h", tag, res_q, sr_q, exp_res, exp_sr);
    end
  endtask

  task automatic op(input logic g, input logic bm, input logic [15:0] d, input logic [15:0] s,
                    input logic [15:0] sr, input string tag);
    @(negedge clk);
    go = g; byte_mode = bm; dst = d; src = s; sr_in = sr;
    @(posedge clk); model();
    @(negedge clk); cmp(tag);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: res=%h sr=%h expected completion", res_q, sr_q);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(posedge clk); model(); @(negedge clk); cmp("R9 reset");
    rst = 0;
    op(1, 0, 16'h0005, 16'h0003, 16'h0000, "R1 R3 word no borrow");
    op(1, 0, 16'h0003, 16'h0005, 16'h0038, "R3 R5 R7 word borrow");
    op(1, 0, 16'h1234, 16'h1234, 16'hFEF8, "R4 R7 word zero");
    op(1, 0, 16'h8000, 16'h0001, 16'h0000, "R6 word overflow neg-pos");
    op(1, 0, 16'h7FFF, 16'hFFFF, 16'h0000, "R6 word overflow pos-neg");
    op(1, 0, 16'h0000, 16'h0000, 16'hA5A5, "R4 R7 zero zero");
    op(1, 1, 16'hAB05, 16'hCD03, 16'h0000, "R2 byte no borrow");
    op(1, 1, 16'h1180, 16'h2201, 16'h0010, "R2 R6 byte overflow");
    op(1, 1, 16'hFF42, 16'h0042, 16'h0000, "R4 byte zero");
    op(1, 1, 16'h0001, 16'h0002, 16'h0020, "R3 R5 byte borrow");
    op(1, 1, 16'h007F, 16'h00FF, 16'h0000, "R6 byte pos-neg");
    op(0, 0, 16'h0000, 16'h1111, 16'h0000, "R8 idle hold");
    op(0, 1, 16'h5555, 16'h0001, 16'hFFFF, "R8 idle hold 2");
    for (int i = 0; i < 300; i++)
      op(($urandom % 4) != 0, $urandom % 2, 16'($urandom), 16'($urandom), 16'($urandom), "R1 random");
    @(negedge clk); rst = 1;
    @(posedge clk); model(); @(negedge clk); cmp("R9 late reset");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule